// File: doc/BRIEF.md
# Two-Wire Serial Byte Engine

This block is a serial master for an external two-wire memory device, driven one primitive at a time by a processor. The processor loads an 8-bit data register and then writes a 4-bit command into the low nibble of a control register. Each command runs one bus primitive: a start condition, a stop condition, sending the data byte, receiving a byte and acknowledging it, or receiving a final byte with no acknowledge. A whole transaction is built from a series of these commands, and the processor waits between them for BUSY to fall or for the interrupt.

The upper nibble of the control register reports status. This covers busy, an error flag for illegal commands, and two active-low acknowledge flags: one for what the slave answered and one for what the master sent. The serial clock comes from a parameterized divider. One bit time on the bus is four quarter periods of `DIV` system clocks each. The data line is open-drain: the block pulls it low through an output enable and reads the wired line back. Once a bus command has run, the clock keeps toggling while the block is idle. A no-op command parks it high.

Top module: `twi_byte_engine`

## Requirements
- R1: After reset, `ctrl_rdata` reads 8'h30. Its fields are bit 7 ERROR, bit 6 BUSY, bit 5 RX_ACK and bit 4 TX_ACK, and bits 3..0 always read 0. At the same time `data_rdata` is 0, `sck` is 1, `sda_oe` is 0, `irq` is 0, and the clock does not toggle.
- R2: The command codes are 0000 no-op, 1001 start, 0101 stop, 0011 transmit the data register, 0001 receive with acknowledge, and 0110 receive the last byte with no acknowledge.
- R3: Writing any other code while idle causes no bus activity, no BUSY and no `irq`, and it sets ERROR to 1. The next legal command written while idle clears ERROR to 0.
- R4: BUSY goes high in the cycle after the command write and stays high for exactly 4*DIV cycles for a start or a stop, and 36*DIV cycles for a byte command.
- R5: `irq` is high for exactly one cycle: the first cycle in which BUSY reads 0 after a bus command.
- R6: A transmit sends the data register MSB first, with one bit per rising SCK edge over eight edges. On the ninth edge the slave owns the line, and RX_ACK then holds the line level sampled there (0 means acknowledged).
- R7: A receive shifts eight line samples MSB first into the data register. A receive with acknowledge pulls the line low on the ninth clock and leaves TX_ACK=0. A receive of the last byte releases the line on the ninth clock and leaves TX_ACK=1.
- R8: During byte commands the data line changes only while SCK is low. A start pulls the line low while SCK is high, and a stop releases it while SCK is high. Each start or stop command produces exactly one such condition.
- R9: The SCK period is 4*DIV system clocks. After a bus command, SCK keeps toggling while the block is idle. After a no-op it stays high.
- R10: While BUSY is high, command writes and data writes are ignored. ERROR, the data register and the running transfer are all unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_wr | input | 1 | Write strobe for the data register |
| data_wdata | input | 8 | Value to load into the data register |
| data_rdata | output | 8 | Data register contents |
| ctrl_wr | input | 1 | Write strobe for the command field |
| ctrl_wdata | input | 4 | Command code |
| ctrl_rdata | output | 8 | Status nibble above a zero nibble |
| sck | output | 1 | Serial clock |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| sda_i | input | 1 | Wired level of the data line |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the processor never asserts `ctrl_wr` and `data_wr` in the same cycle. They also assume that `sda_i` moves only when the master changes `sda_oe` or when the slave changes its pull while SCK is low. The bench slave model moves its pull only on a falling SCK edge. Before starting a command while the clock free-runs, the bench waits for a fresh low phase of SCK, so that arming a receive never moves the line while the clock is high. Random data bytes, slave acknowledge choices and illegal codes are all drawn inside these limits.

// File: rtl/twi_eng_pkg.sv
// Shared command codes, operation kinds and decode helpers for the
// two-wire byte engine. Assumes a 4-bit command field.
package twi_eng_pkg;

    typedef enum logic [3:0] {
        CMD_NOP     = 4'b0000,
        CMD_RD_ACK  = 4'b0001,
        CMD_WR      = 4'b0011,
        CMD_STOP    = 4'b0101,
        CMD_RD_LAST = 4'b0110,
        CMD_START   = 4'b1001
    } cmd_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_START, OP_STOP, OP_WR, OP_RD_ACK, OP_RD_LAST
    } op_e;

    localparam int unsigned BYTE_BITS = 8;

    // True for every defined code, including the no-op.
    function automatic logic cmd_legal(input logic [3:0] c);
        case (c)
            CMD_NOP, CMD_RD_ACK, CMD_WR, CMD_STOP, CMD_RD_LAST, CMD_START: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Maps a code to the bus operation it launches (none for no-op/illegal).
    function automatic op_e cmd_to_op(input logic [3:0] c);
        case (c)
            CMD_START:   return OP_START;
            CMD_STOP:    return OP_STOP;
            CMD_WR:      return OP_WR;
            CMD_RD_ACK:  return OP_RD_ACK;
            CMD_RD_LAST: return OP_RD_LAST;
            default:     return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/twi_qtr_div.sv
// Quarter-period tick generator. Emits one tick every DIV cycles while
// run is high; restart realigns the count so a new command starts on a
// full quarter. Assumes DIV >= 1.
module twi_qtr_div #(
    parameter int unsigned DIV = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count system clocks within one quarter of the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && !restart && (cnt == LAST);
endmodule

// File: rtl/twi_bit_seq.sv
// Bit-slot sequencer. Runs one operation as slots of four quarters
// (SCK low in quarters 0-1, high in 2-3), samples the line entering
// quarter 2 and drives the line from quarter 1. Assumes tx_byte is held
// stable while busy and that ticks arrive only from the divider.
module twi_bit_seq
    import twi_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  op_e        op_in,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       sda_i,
    input  logic       free_run,
    output logic       busy,
    output logic       done,
    output op_e        op_cur,
    output logic [7:0] rx_byte,
    output logic       ack_bit,
    output logic       sck,
    output logic       sda_oe
);
    localparam logic [3:0] ACK_SLOT = 4'(BYTE_BITS);

    logic [1:0] q;
    logic [3:0] slot;
    logic       oe_hold;
    logic [2:0] bit_idx;
    logic       is_byte;
    logic       is_rd;
    logic       last_slot;

    assign is_rd     = (op_cur == OP_RD_ACK) || (op_cur == OP_RD_LAST);
    assign is_byte   = is_rd || (op_cur == OP_WR);
    assign last_slot = !is_byte || (slot == ACK_SLOT);
    assign bit_idx   = 3'(4'd7 - slot);
    assign rx_byte   = rx_shift;

    logic [7:0] rx_shift;

    // Advance quarters and slots, capture line samples, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            op_cur   <= OP_NONE;
            q        <= '0;
            slot     <= '0;
            rx_shift <= '0;
            ack_bit  <= 1'b1;
        end else begin
            done <= 1'b0;
            if (launch) begin
                op_cur <= op_in;
                busy   <= 1'b1;
                q      <= '0;
                slot   <= '0;
            end else if (tick) begin
                if (busy && q == 2'd1 && is_byte && slot == ACK_SLOT) begin
                    ack_bit <= sda_i;
                end
                if (busy && q == 2'd1 && is_rd && slot != ACK_SLOT) begin
                    rx_shift <= {rx_shift[6:0], sda_i};
                end
                if (q == 2'd3) begin
                    q <= '0;
                    if (busy && last_slot) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else if (busy) begin
                        slot <= slot + 1'b1;
                    end
                end else begin
                    q <= q + 1'b1;
                end
            end
        end
    end

    // Remember the last driven line state for quarter 0 and idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_hold <= 1'b0;
        end else begin
            oe_hold <= sda_oe;
        end
    end

    // Derive the clock and the line pull from the sequencer state.
    always_comb begin
        sck    = 1'b1;
        sda_oe = oe_hold;
        if (busy) begin
            sck = q[1];
            if (q != 2'd0) begin
                case (op_cur)
                    OP_START:   sda_oe = (q == 2'd3);
                    OP_STOP:    sda_oe = (q != 2'd3);
                    OP_WR:      sda_oe = (slot == ACK_SLOT) ? 1'b0 : !tx_byte[bit_idx];
                    OP_RD_ACK:  sda_oe = (slot == ACK_SLOT);
                    OP_RD_LAST: sda_oe = 1'b0;
                    default:    sda_oe = oe_hold;
                endcase
            end
        end else if (free_run) begin
            sck = q[1];
        end
    end
endmodule

// File: rtl/twi_byte_engine.sv
// Command-driven two-wire master. Holds the data and status registers,
// decodes commands written while idle and launches one bus primitive
// per command. Assumes ctrl_wr and data_wr are not asserted together.
module twi_byte_engine
    import twi_eng_pkg::*;
#(
    parameter int unsigned DIV = 160
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       data_wr,
    input  logic [7:0] data_wdata,
    output logic [7:0] data_rdata,
    input  logic       ctrl_wr,
    input  logic [3:0] ctrl_wdata,
    output logic [7:0] ctrl_rdata,
    output logic       sck,
    output logic       sda_oe,
    input  logic       sda_i,
    output logic       irq
);
    logic [7:0] data_q;
    logic       err_q;
    logic       rx_ack_q;
    logic       tx_ack_q;
    logic       free_run_q;
    logic       busy;
    logic       done;
    logic       tick;
    logic       launch;
    logic       legal;
    logic       ack_bit;
    logic [7:0] rx_byte;
    op_e        op_new;
    op_e        op_cur;

    assign legal  = cmd_legal(ctrl_wdata);
    assign op_new = cmd_to_op(ctrl_wdata);
    assign launch = ctrl_wr && !busy && (op_new != OP_NONE);

    twi_qtr_div #(.DIV(DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy || free_run_q),
        .restart (launch),
        .tick    (tick)
    );

    twi_bit_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .op_in    (op_new),
        .tx_byte  (data_q),
        .tick     (tick),
        .sda_i    (sda_i),
        .free_run (free_run_q),
        .busy     (busy),
        .done     (done),
        .op_cur   (op_cur),
        .rx_byte  (rx_byte),
        .ack_bit  (ack_bit),
        .sck      (sck),
        .sda_oe   (sda_oe)
    );

    // Command acceptance, error flag and idle clock enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q      <= 1'b0;
            free_run_q <= 1'b0;
        end else if (ctrl_wr && !busy) begin
            err_q <= !legal;
            if (legal) begin
                free_run_q <= (op_new != OP_NONE);
            end
        end
    end

    // Data register and acknowledge flags, updated by writes and completions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            rx_ack_q <= 1'b1;
            tx_ack_q <= 1'b1;
        end else begin
            if (data_wr && !busy) begin
                data_q <= data_wdata;
            end
            if (done) begin
                case (op_cur)
                    OP_WR:      rx_ack_q <= ack_bit;
                    OP_RD_ACK:  begin data_q <= rx_byte; tx_ack_q <= 1'b0; end
                    OP_RD_LAST: begin data_q <= rx_byte; tx_ack_q <= 1'b1; end
                    default:    ;
                endcase
            end
        end
    end

    assign data_rdata = data_q;
    assign ctrl_rdata = {err_q, busy, rx_ack_q, tx_ack_q, 4'b0000};
    assign irq        = done;
endmodule

// File: rtl/twi_byte_engine_chk.sv
// Property checker for the two-wire byte engine, bound to its top.
module twi_byte_engine_chk
    import twi_eng_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       irq,
    input logic       sck,
    input logic       sda_oe,
    input logic       err,
    input logic       ctrl_wr,
    input logic       data_wr,
    input logic       free_run,
    input op_e        op,
    input logic [7:0] data_q
);
    AST_IRQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && $past(busy))); // R5
    AST_BUSY_END_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq); // R5
    AST_LINE_HELD_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && sck && $past(sck) && (op inside {OP_WR, OP_RD_ACK, OP_RD_LAST}))
        |-> $stable(sda_oe)); // R8
    AST_PARKED_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !free_run) |-> sck); // R9
    AST_ERR_RISE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy); // R3
    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && busy) |=> $stable(err)); // R10
    AST_BUSY_DATA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && busy && op == OP_WR) |=> $stable(data_q)); // R10
endmodule

bind twi_byte_engine twi_byte_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .irq      (irq),
    .sck      (sck),
    .sda_oe   (sda_oe),
    .err      (err_q),
    .ctrl_wr  (ctrl_wr),
    .data_wr  (data_wr),
    .free_run (free_run_q),
    .op       (op_cur),
    .data_q   (data_q)
);

// File: tb/twi_byte_engine_bench.sv
`timescale 1ns/1ps
module twi_byte_engine_bench;
    localparam int BDIV = 4;
    localparam int SLOT_LEN = 4 * BDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] data_wdata = '0;
    logic [7:0] data_rdata;
    logic       ctrl_wr = 1'b0;
    logic [3:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rdata;
    logic       sck;
    logic       sda_oe;
    logic       sda_line;
    logic       irq;

    int checks = 0;
    int errors = 0;

    // slave model state
    int         cur_op = 0;      // 0 none, 1 transmit, 2 receive
    int         pos_cnt = 0;
    int         slave_bit = 0;
    logic [7:0] slave_byte = '0;
    logic       slave_ack_en = 1'b0;
    logic [7:0] cap_byte = '0;
    logic       cap_ack_line = 1'b1;
    int         start_cnt = 0;
    int         stop_cnt = 0;
    logic       slave_pull;
    logic       fr_exp = 1'b0;

    always #5 clk = ~clk;

    assign slave_pull = (cur_op == 1 && slave_bit == 8 && slave_ack_en) ||
                        (cur_op == 2 && slave_bit < 8 && !slave_byte[7 - slave_bit]);
    assign sda_line = !(sda_oe || slave_pull);

    twi_byte_engine #(.DIV(BDIV)) u_twi_byte_engine (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_wdata(data_wdata),
        .data_rdata(data_rdata), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .sck(sck), .sda_oe(sda_oe), .sda_i(sda_line),
        .irq(irq)
    );

    // Slave: capture line on rising SCK while a command runs.
    always @(posedge sck) begin
        if (ctrl_rdata[6] === 1'b1) begin
            if (pos_cnt < 8) cap_byte <= {cap_byte[6:0], sda_line};
            if (pos_cnt == 8) cap_ack_line <= sda_line;
            pos_cnt <= pos_cnt + 1;
        end
    end

    // Slave: move its own pull only after SCK falls.
    always @(negedge sck) slave_bit <= pos_cnt;

    // Bus condition monitor: line edges while SCK is high.
    always @(negedge sda_line) if (sck === 1'b1) start_cnt++;
    always @(posedge sda_line) if (sck === 1'b1) stop_cnt++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] status(input logic e, b, rx, tx);
        return {e, b, rx, tx, 4'b0000};
    endfunction

    function automatic logic legal_code(input logic [3:0] c);
        return c inside {4'h0, 4'h1, 4'h3, 4'h5, 4'h6, 4'h9};
    endfunction

    task automatic wr_data(input logic [7:0] b);
        @(negedge clk); data_wr = 1'b1; data_wdata = b;
        @(negedge clk); data_wr = 1'b0;
    endtask

    // Runs one bus command, checks length and interrupt pulse.
    task automatic bus_cmd(input logic [3:0] c, input int op_code, input int exp_len, input bit inject);
        int len;
        if (fr_exp) @(negedge sck);
        @(negedge clk);
        pos_cnt = 0; slave_bit = 0; cur_op = op_code;
        ctrl_wr = 1'b1; ctrl_wdata = c;
        @(negedge clk); ctrl_wr = 1'b0;
        len = 0;
        while (ctrl_rdata[6] === 1'b1 && len < 100000) begin
            len++;
            if (inject && len == 10) begin
                ctrl_wr = 1'b1; ctrl_wdata = 4'hF; data_wr = 1'b1; data_wdata = 8'hFF;
            end else begin
                ctrl_wr = 1'b0; data_wr = 1'b0;
            end
            @(negedge clk);
        end
        ctrl_wr = 1'b0; data_wr = 1'b0;
        check("R4 busy length", len, exp_len);
        check("R5 irq at busy fall", irq, 1'b1);
        cur_op = 0;
        fr_exp = 1'b1;
        @(negedge clk);
        check("R5 irq one cycle", irq, 1'b0);
    endtask

    task automatic bad_cmd(input logic [3:0] c);
        int s0, p0;
        s0 = start_cnt; p0 = stop_cnt;
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = c;
        @(negedge clk); ctrl_wr = 1'b0;
        check("R3 error set", ctrl_rdata[7], 1'b1);
        check("R3 no busy", ctrl_rdata[6], 1'b0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (irq !== 1'b0 || ctrl_rdata[6] !== 1'b0) check("R3 no activity", {irq, ctrl_rdata[6]}, 2'b00);
        end
        check("R3 no bus condition", start_cnt + stop_cnt, s0 + p0);
    endtask

    task automatic transfer_round(input logic [7:0] wbyte, input logic ack, input logic [7:0] r1, input logic [7:0] r2);
        int s0, p0;
        s0 = start_cnt; p0 = stop_cnt;
        bus_cmd(4'b1001, 0, SLOT_LEN, 1'b0);
        check("R8 start condition", start_cnt, s0 + 1);
        check("R3 error cleared", ctrl_rdata[7], 1'b0);
        wr_data(wbyte);
        slave_ack_en = ack;
        bus_cmd(4'b0011, 1, 9 * SLOT_LEN, 1'b0);
        check("R6 byte sent MSB first", cap_byte, wbyte);
        check("R6 slave ack flag", ctrl_rdata[5], !ack);
        slave_byte = r1;
        bus_cmd(4'b0001, 2, 9 * SLOT_LEN, 1'b0);
        check("R7 byte received", data_rdata, r1);
        check("R7 master ack driven", cap_ack_line, 1'b0);
        check("R7 tx ack flag", ctrl_rdata[4], 1'b0);
        slave_byte = r2;
        bus_cmd(4'b0110, 2, 9 * SLOT_LEN, 1'b0);
        check("R7 last byte received", data_rdata, r2);
        check("R7 no ack on last", cap_ack_line, 1'b1);
        check("R7 tx ack flag last", ctrl_rdata[4], 1'b1);
        bus_cmd(4'b0101, 0, SLOT_LEN, 1'b0);
        check("R8 stop condition", stop_cnt, p0 + 1);
        check("R8 no stray conditions", start_cnt, s0 + 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int tog;
        time t0, t1;
        logic [3:0] c;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status reset", ctrl_rdata, status(1'b0, 1'b0, 1'b1, 1'b1));
        check("R1 data reset", data_rdata, 8'h00);
        check("R1 sck/oe/irq reset", {sck, sda_oe, irq}, 3'b100);
        tog = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (sck !== 1'b1) tog++; end
        check("R1 clock parked after reset", tog, 0);

        // Directed round with fixed patterns (R2 codes)
        transfer_round(8'hA5, 1'b1, 8'hC3, 8'h81);
        transfer_round(8'h01, 1'b0, 8'h80, 8'h7E);

        // R10 writes during busy are ignored
        bus_cmd(4'b1001, 0, SLOT_LEN, 1'b0);
        wr_data(8'h5A);
        slave_ack_en = 1'b1;
        bus_cmd(4'b0011, 1, 9 * SLOT_LEN, 1'b1);
        check("R10 error unchanged", ctrl_rdata[7], 1'b0);
        check("R10 data unchanged", data_rdata, 8'h5A);
        check("R10 transfer intact", cap_byte, 8'h5A);
        bus_cmd(4'b0101, 0, SLOT_LEN, 1'b0);

        // R9 free-running period while idle
        @(posedge sck); t0 = $time;
        @(posedge sck); t1 = $time;
        check("R9 sck period", int'((t1 - t0) / 10), 4 * BDIV);

        // R3 illegal codes then clearing by no-op
        bad_cmd(4'hF);
        bad_cmd(4'h2);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = 4'b0000;
        @(negedge clk); ctrl_wr = 1'b0;
        check("R3 no-op clears error", ctrl_rdata, status(1'b0, 1'b0, 1'b0, 1'b1));
        fr_exp = 1'b0;
        tog = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (sck !== 1'b1) tog++; end
        check("R9 clock parked after no-op", tog, 0);

        // Random rounds with mixed illegal codes
        for (int k = 0; k < 12; k++) begin
            if ($urandom % 2) begin
                do c = 4'($urandom); while (legal_code(c));
                bad_cmd(c);
            end
            transfer_round(8'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule